// File: doc/BRIEF.md
# Banked ROM Address Mapper

This block turns a CPU bus address inside the 32 KiB program window and a PPU bus address inside the 8 KiB pattern space into physical ROM addresses. It works from the current contents of the bank registers, which are held outside the block. It is purely combinational. The register write decoding, any interrupt counter and the ROM arrays themselves are not part of it. The sizes of the program ROM and the pattern ROM are set by parameters.

The program window is split into four 8 KiB slots. Two of them take their bank numbers from switchable selectors, and the other two are pinned to the last and second-to-last banks. A swap bit decides whether slot 0 or slot 2 holds the pinned second-to-last bank. The pattern space is split into eight 1 KiB slots. Each slot's bank number is built from a 4-bit low part and a 5-bit high part. A build-time variant shifts every pattern bank number right by one place, so the low bit is ignored.

The block also produces the single nametable select line from a 2-bit mirroring code.

Top module: `banked_rom_mapper`

## Requirements
- R1: With `prg_swap` = 0, program slot 0 (cpu_win_addr[14:13] = 0) uses `prg_sel0`, slot 1 uses `prg_sel1`, and slot 2 uses bank PRG_BANKS-2.
- R2: With `prg_swap` = 1, program slot 0 uses bank PRG_BANKS-2, slot 1 uses `prg_sel1`, and slot 2 uses `prg_sel0`.
- R3: Program slot 3 always uses bank PRG_BANKS-1, whatever the values of `prg_swap` and the selectors.
- R4: `prg_addr` is the slot's bank number in the upper bits, followed by cpu_win_addr[12:0] unchanged in bits [12:0].
- R5: Pattern slot k, selected by ppu_addr[12:10], has the raw bank number chr_lo[4k+3:4k] OR (chr_hi[5k+4:5k] shifted left by 4). This 9-bit value is used directly when HALF_CHR = 0.
- R6: When HALF_CHR = 1, the raw 9-bit pattern bank number is shifted right by one before it is used, so its bit 0 has no effect on `chr_addr`.
- R7: `nt_sel` equals ppu_addr[10] for mirroring code 0, equals ppu_addr[11] for code 1, is constant 0 for code 2 and is constant 1 for code 3.
- R8: Every selected program bank number is reduced modulo PRG_BANKS. Every pattern bank number is reduced modulo CHR_BANKS, after the shift of R6 where that applies.
- R9: `chr_addr` is the pattern bank number in the upper bits, followed by ppu_addr[9:0] unchanged in bits [9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_win_addr | input | 15 | CPU address bits 14..0 within the 0x8000–0xFFFF window |
| prg_sel0 | input | 5 | First switchable program bank selector |
| prg_sel1 | input | 5 | Second switchable program bank selector |
| prg_swap | input | 1 | Chooses whether slot 0 or slot 2 holds the pinned second-to-last bank |
| ppu_addr | input | 13 | PPU pattern-space address bits 12..0 |
| chr_lo | input | 32 | Eight 4-bit low parts of the pattern bank numbers; slot k is in bits [4k+3:4k] |
| chr_hi | input | 40 | Eight 5-bit high parts of the pattern bank numbers; slot k is in bits [5k+4:5k] |
| mirror | input | 2 | Mirroring code: 0 vertical, 1 horizontal, 2 single screen A, 3 single screen B |
| prg_addr | output | PRG_BW+13 | Physical program ROM address |
| chr_addr | output | CHR_BW+10 | Physical pattern ROM address |
| nt_sel | output | 1 | Nametable select line |

## Verification
The assertions assume that every input is driven to a known value. They are evaluated only when no input or output bit is unknown, so the period before the bench first drives the inputs is skipped. The bench drives all inputs at the falling clock edge and samples one nanosecond later, after the combinational paths have settled. Its selector and bank values are kept within the field widths given in the port table, so the wrap behaviour that is checked comes from the modulo reduction alone, never from truncation at the ports.

// File: rtl/mapper_pkg.sv
// Package: shared constants and types for the banked ROM address mapper.
// Assumes: fixed field widths of the bank selectors and slot geometry.
package mapper_pkg;

    localparam int PRG_SEL_W  = 5;   // width of a program bank selector
    localparam int PRG_OFS_W  = 13;  // 8 KiB program slot offset
    localparam int PRG_SLOTS  = 4;
    localparam int PRG_SLOT_W = $clog2(PRG_SLOTS);
    localparam int CHR_LO_W   = 4;   // low part of a pattern bank number
    localparam int CHR_HI_W   = 5;   // high part of a pattern bank number
    localparam int CHR_RAW_W  = CHR_LO_W + CHR_HI_W;
    localparam int CHR_OFS_W  = 10;  // 1 KiB pattern slot offset
    localparam int CHR_SLOTS  = 8;
    localparam int CHR_SLOT_W = $clog2(CHR_SLOTS);

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORIZ  = 2'd1,
        MIR_ONE_A  = 2'd2,
        MIR_ONE_B  = 2'd3
    } mirror_e;

endpackage

// File: rtl/prg_slot_map.sv
// Module: prg_slot_map
// Picks the program bank number for one of the four 8 KiB CPU slots.
// Assumes: PRG_BANKS >= 2; selectors are reduced modulo PRG_BANKS.
module prg_slot_map
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    parameter int PRG_BW    = $clog2(PRG_BANKS)
) (
    input  logic [PRG_SLOT_W-1:0] slot,
    input  logic [PRG_SEL_W-1:0]  sel0,
    input  logic [PRG_SEL_W-1:0]  sel1,
    input  logic                  swap,
    output logic [PRG_BW-1:0]     bank
);

    localparam logic [PRG_BW-1:0] LAST_BANK   = PRG_BW'(PRG_BANKS - 1);
    localparam logic [PRG_BW-1:0] SECOND_BANK = PRG_BW'(PRG_BANKS - 2);

    logic [PRG_BW-1:0] sel0_wrap;
    logic [PRG_BW-1:0] sel1_wrap;

    // Reduce both selectors into the available bank range.
    always_comb begin
        sel0_wrap = PRG_BW'(32'(sel0) % PRG_BANKS);
        sel1_wrap = PRG_BW'(32'(sel1) % PRG_BANKS);
    end

    // Route selectors or pinned banks to the slot per swap mode.
    always_comb begin
        unique case (slot)
            2'd0:    bank = swap ? SECOND_BANK : sel0_wrap;
            2'd1:    bank = sel1_wrap;
            2'd2:    bank = swap ? sel0_wrap : SECOND_BANK;
            default: bank = LAST_BANK;
        endcase
    end

endmodule

// File: rtl/chr_slot_map.sv
// Module: chr_slot_map
// Builds eight 1 KiB pattern bank numbers from split low/high parts and
// selects the one addressed by the PPU slot index.
// Assumes: HALF_CHR is 0 or 1; results are reduced modulo CHR_BANKS.
module chr_slot_map
    import mapper_pkg::*;
#(
    parameter int CHR_BANKS = 256,
    parameter bit HALF_CHR  = 1'b0,
    parameter int CHR_BW    = $clog2(CHR_BANKS)
) (
    input  logic [CHR_SLOT_W-1:0]          slot,
    input  logic [CHR_SLOTS*CHR_LO_W-1:0]  lo_parts,
    input  logic [CHR_SLOTS*CHR_HI_W-1:0]  hi_parts,
    output logic [CHR_BW-1:0]              bank
);

    logic [CHR_BW-1:0] slot_bank [CHR_SLOTS];

    for (genvar k = 0; k < CHR_SLOTS; k++) begin : g_slot
        logic [CHR_RAW_W-1:0] raw;
        logic [CHR_RAW_W-1:0] eff;

        // Merge the high part above the low part.
        always_comb begin
            raw = (CHR_RAW_W'(hi_parts[k*CHR_HI_W +: CHR_HI_W]) << CHR_LO_W)
                | CHR_RAW_W'(lo_parts[k*CHR_LO_W +: CHR_LO_W]);
        end

        if (HALF_CHR) begin : g_half
            // Variant: discard bit 0 of the merged number.
            always_comb eff = raw >> 1;
        end else begin : g_full
            // Standard: merged number used as is.
            always_comb eff = raw;
        end

        // Reduce into the available pattern bank range.
        always_comb slot_bank[k] = CHR_BW'(32'(eff) % CHR_BANKS);
    end

    // Pick the bank for the addressed slot.
    always_comb bank = slot_bank[slot];

endmodule

// File: rtl/nt_select.sv
// Module: nt_select
// Derives the nametable select line from the mirroring code.
// Assumes: code encoding from mapper_pkg::mirror_e.
module nt_select
    import mapper_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       a10,
    input  logic       a11,
    output logic       sel
);

    // Decode mirroring code into the select source.
    always_comb begin
        unique case (mirror_e'(mode))
            MIR_VERT:  sel = a10;
            MIR_HORIZ: sel = a11;
            MIR_ONE_A: sel = 1'b0;
            default:   sel = 1'b1;
        endcase
    end

endmodule

// File: rtl/banked_rom_mapper.sv
// Module: banked_rom_mapper (top)
// Translates CPU window and PPU pattern addresses into physical ROM
// addresses from externally held bank selectors; also drives the
// nametable select. Purely combinational.
// Assumes: cpu_win_addr is only meaningful while the CPU is in 0x8000-0xFFFF.
module banked_rom_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    parameter int CHR_BANKS = 256,
    parameter bit HALF_CHR  = 1'b0,
    parameter int PRG_BW    = $clog2(PRG_BANKS),
    parameter int CHR_BW    = $clog2(CHR_BANKS)
) (
    input  logic [14:0]                   cpu_win_addr,
    input  logic [4:0]                    prg_sel0,
    input  logic [4:0]                    prg_sel1,
    input  logic                          prg_swap,
    input  logic [12:0]                   ppu_addr,
    input  logic [31:0]                   chr_lo,
    input  logic [39:0]                   chr_hi,
    input  logic [1:0]                    mirror,
    output logic [PRG_BW+PRG_OFS_W-1:0]   prg_addr,
    output logic [CHR_BW+CHR_OFS_W-1:0]   chr_addr,
    output logic                          nt_sel
);

    logic [PRG_BW-1:0] prg_bank;
    logic [CHR_BW-1:0] chr_bank;

    prg_slot_map #(
        .PRG_BANKS (PRG_BANKS),
        .PRG_BW    (PRG_BW)
    ) u_prg (
        .slot (cpu_win_addr[14:13]),
        .sel0 (prg_sel0),
        .sel1 (prg_sel1),
        .swap (prg_swap),
        .bank (prg_bank)
    );

    chr_slot_map #(
        .CHR_BANKS (CHR_BANKS),
        .HALF_CHR  (HALF_CHR),
        .CHR_BW    (CHR_BW)
    ) u_chr (
        .slot     (ppu_addr[12:10]),
        .lo_parts (chr_lo),
        .hi_parts (chr_hi),
        .bank     (chr_bank)
    );

    nt_select u_nt (
        .mode (mirror),
        .a10  (ppu_addr[10]),
        .a11  (ppu_addr[11]),
        .sel  (nt_sel)
    );

    // Join bank numbers with in-slot offsets.
    always_comb begin
        prg_addr = {prg_bank, cpu_win_addr[PRG_OFS_W-1:0]};
        chr_addr = {chr_bank, ppu_addr[CHR_OFS_W-1:0]};
    end

endmodule

// File: rtl/mapper_checker.sv
// Module: mapper_checker
// Assertion checker bound to banked_rom_mapper; evaluated whenever all
// observed signals are known.
module mapper_checker #(
    parameter int PRG_BANKS = 16,
    parameter int PRG_BW    = $clog2(PRG_BANKS),
    parameter int CHR_BW    = 8
) (
    input logic [14:0]           cpu_win_addr,
    input logic [4:0]            prg_sel0,
    input logic [4:0]            prg_sel1,
    input logic                  prg_swap,
    input logic [12:0]           ppu_addr,
    input logic [1:0]            mirror,
    input logic [PRG_BW+12:0]    prg_addr,
    input logic [CHR_BW+9:0]     chr_addr,
    input logic                  nt_sel
);

    logic [PRG_BW-1:0] obs_bank;
    logic              known;

    // Gather observed bank and known-ness of all sampled signals.
    always_comb begin
        obs_bank = prg_addr[PRG_BW+12:13];
        known = !$isunknown({cpu_win_addr, prg_sel0, prg_sel1, prg_swap,
                             ppu_addr, mirror, prg_addr, chr_addr, nt_sel});
    end

    // Immediate checks on the combinational outputs.
    always_comb begin
        if (known) begin
            p_last_slot_r3: assert (cpu_win_addr[14:13] != 2'd3 ||
                                    32'(obs_bank) == PRG_BANKS - 1)
                else $error("last slot not pinned");
            p_swap_slot0_r2: assert (!(prg_swap && cpu_win_addr[14:13] == 2'd0) ||
                                     32'(obs_bank) == PRG_BANKS - 2)
                else $error("swap slot 0 wrong");
            p_plain_slot2_r1: assert (!(!prg_swap && cpu_win_addr[14:13] == 2'd2) ||
                                      32'(obs_bank) == PRG_BANKS - 2)
                else $error("plain slot 2 wrong");
            p_slot1_wrap_r8: assert (cpu_win_addr[14:13] != 2'd1 ||
                                     32'(obs_bank) == 32'(prg_sel1) % PRG_BANKS)
                else $error("slot 1 wrap wrong");
            p_prg_offset_r4: assert (prg_addr[12:0] == cpu_win_addr[12:0])
                else $error("prg offset altered");
            p_chr_offset_r9: assert (chr_addr[9:0] == ppu_addr[9:0])
                else $error("chr offset altered");
            p_nt_single_r7: assert (mirror[1] == 1'b0 || nt_sel == mirror[0])
                else $error("single screen select wrong");
        end
    end

endmodule

bind banked_rom_mapper mapper_checker #(
    .PRG_BANKS (PRG_BANKS),
    .PRG_BW    (PRG_BW),
    .CHR_BW    (CHR_BW)
) u_mapper_checker (
    .cpu_win_addr (cpu_win_addr),
    .prg_sel0     (prg_sel0),
    .prg_sel1     (prg_sel1),
    .prg_swap     (prg_swap),
    .ppu_addr     (ppu_addr),
    .mirror       (mirror),
    .prg_addr     (prg_addr),
    .chr_addr     (chr_addr),
    .nt_sel       (nt_sel)
);

// File: tb/test_banked_rom_mapper.sv
`timescale 1ns/1ps
module test_banked_rom_mapper;

    localparam int PB = 16;
    localparam int CB = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [14:0] cpu_win_addr;
    logic [4:0]  prg_sel0, prg_sel1;
    logic        prg_swap;
    logic [12:0] ppu_addr;
    logic [31:0] chr_lo;
    logic [39:0] chr_hi;
    logic [1:0]  mirror;
    logic [16:0] prg_addr, prg_addr_h;
    logic [17:0] chr_addr, chr_addr_h;
    logic        nt_sel, nt_sel_h;

    int n_chk = 0;
    int n_bad = 0;

    banked_rom_mapper #(.PRG_BANKS(PB), .CHR_BANKS(CB), .HALF_CHR(1'b0)) i_banked_rom_mapper (
        .cpu_win_addr(cpu_win_addr), .prg_sel0(prg_sel0), .prg_sel1(prg_sel1),
        .prg_swap(prg_swap), .ppu_addr(ppu_addr), .chr_lo(chr_lo), .chr_hi(chr_hi),
        .mirror(mirror), .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_sel(nt_sel));

    banked_rom_mapper #(.PRG_BANKS(PB), .CHR_BANKS(CB), .HALF_CHR(1'b1)) i_banked_rom_mapper_half (
        .cpu_win_addr(cpu_win_addr), .prg_sel0(prg_sel0), .prg_sel1(prg_sel1),
        .prg_swap(prg_swap), .ppu_addr(ppu_addr), .chr_lo(chr_lo), .chr_hi(chr_hi),
        .mirror(mirror), .prg_addr(prg_addr_h), .chr_addr(chr_addr_h), .nt_sel(nt_sel_h));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected program address from the requirements.
    function automatic logic [31:0] exp_prg(input int slot, input int ofs,
                                            input int s0, input int s1, input bit sw);
        int b;
        case (slot)
            0: b = sw ? PB - 2 : s0 % PB;
            1: b = s1 % PB;
            2: b = sw ? s0 % PB : PB - 2;
            default: b = PB - 1;
        endcase
        return 32'(b * 8192 + ofs);
    endfunction

    // Expected pattern address from the requirements.
    function automatic logic [31:0] exp_chr(input int lo, input int hi, input int ofs, input bit half);
        int b;
        b = lo | (hi * 16);
        if (half) b = b / 2;
        return 32'((b % CB) * 1024 + ofs);
    endfunction

    task automatic drive_prg(input int slot, input int ofs);
        @(negedge clk);
        cpu_win_addr = 15'(slot * 8192 + ofs);
        #1;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        cpu_win_addr = '0; prg_sel0 = '0; prg_sel1 = '0; prg_swap = 1'b0;
        ppu_addr = '0; chr_lo = '0; chr_hi = '0; mirror = 2'd0;
        #1;
        chk("R1 idle prg", 32'(prg_addr), 32'h0);
        chk("R5 idle chr", 32'(chr_addr), 32'h0);
        chk("R7 idle nt", 32'(nt_sel), 32'h0);
    endtask

    task automatic t_prg_plain;
        prg_sel0 = 5'd3; prg_sel1 = 5'd7; prg_swap = 1'b0;
        for (int s = 0; s < 4; s++) begin
            drive_prg(s, 13'h0ABC);
            chk(s == 3 ? "R3 plain" : "R1 plain", 32'(prg_addr), exp_prg(s, 'hABC, 3, 7, 0));
        end
        drive_prg(1, 13'h1FFF);
        chk("R4 offset top", 32'(prg_addr), exp_prg(1, 'h1FFF, 3, 7, 0));
    endtask

    task automatic t_prg_swap;
        prg_sel0 = 5'd5; prg_sel1 = 5'd9; prg_swap = 1'b1;
        for (int s = 0; s < 4; s++) begin
            drive_prg(s, 13'h0123);
            chk(s == 3 ? "R3 swap" : "R2 swap", 32'(prg_addr), exp_prg(s, 'h123, 5, 9, 1));
        end
    endtask

    task automatic t_prg_wrap;
        prg_sel0 = 5'd21; prg_sel1 = 5'd31; prg_swap = 1'b0;
        drive_prg(0, 13'h0001);
        chk("R8 wrap sel0", 32'(prg_addr), exp_prg(0, 1, 21, 31, 0));
        drive_prg(1, 13'h0002);
        chk("R8 wrap sel1", 32'(prg_addr), exp_prg(1, 2, 21, 31, 0));
        prg_swap = 1'b1;
        drive_prg(2, 13'h0003);
        chk("R8 wrap swapped", 32'(prg_addr), exp_prg(2, 3, 21, 31, 1));
    endtask

    task automatic t_chr_slots;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            chr_lo[k*4 +: 4] = 4'(k * 3 + 1);
            chr_hi[k*5 +: 5] = 5'(k * 4 + 3);
        end
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            ppu_addr = 13'(k * 1024 + 10'h2A5);
            #1;
            chk("R5 chr slot", 32'(chr_addr),
                exp_chr((k * 3 + 1) % 16, (k * 4 + 3) % 32, 'h2A5, 0));
            chk("R6 chr half", 32'(chr_addr_h),
                exp_chr((k * 3 + 1) % 16, (k * 4 + 3) % 32, 'h2A5, 1));
        end
        @(negedge clk);
        chr_lo[4*4 +: 4] = 4'hF; chr_hi[4*5 +: 5] = 5'h1F;
        ppu_addr = 13'(4 * 1024 + 10'h3FF);
        #1;
        chk("R8 chr wrap", 32'(chr_addr), exp_chr(15, 31, 'h3FF, 0));
        chk("R9 chr offset", 32'(chr_addr[9:0]), 32'h3FF);
        chr_lo[4*4 +: 4] = 4'hE;
        #1;
        chk("R6 half bit0 ignored", 32'(chr_addr_h), exp_chr(15, 31, 'h3FF, 1));
        chk("R5 bit0 used", 32'(chr_addr), exp_chr(14, 31, 'h3FF, 0));
    endtask

    task automatic t_mirror;
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 4; a++) begin
                @(negedge clk);
                mirror = 2'(m);
                ppu_addr = 13'(a * 1024);
                #1;
                chk("R7 mirror", 32'(nt_sel),
                    m == 0 ? 32'(a % 2) : m == 1 ? 32'(a / 2) : m == 2 ? 32'h0 : 32'h1);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_prg_plain();
        t_prg_swap();
        t_prg_wrap();
        t_chr_slots();
        t_mirror();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule